// File: doc/BRIEF.md
# UART Double-Buffered Transmit Stage

This block is the serialising half of a UART. The host places one byte at a time into a holding register by pulsing a write strobe with the byte on an 8-bit bus. A separate shift register then sends the byte on the serial line. The pacing comes from a sixteen-times-oversampled baud enable that is generated outside the block. Each frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. Every bit lasts sixteen enable ticks.

There are two registers, so the host can place a second byte while the first is still on the wire. The holding register gives up its byte as soon as the shift register is idle. The "room available" flag rises in that same clock, even though the line is still busy. A second flag reports the moment the whole transmitter has fallen silent: both registers are empty and the last stop bit is complete.

Top module: `uart_tx_stage`

## Requirements
- R1: After a synchronous active-low reset, the serial line is 1, the holding-empty flag is 1 and the transmitter-empty flag is 1.
- R2: Each frame on the serial line has a start bit of 0, then the eight data bits with bit 0 first, then a stop bit of 1. The line rests at 1 between frames.
- R3: Each bit stays on the line for exactly sixteen clocks in which the tick enable is high. While the tick enable is low, a frame in progress does not advance.
- R4: A write strobe while the holding register is empty stores the byte. The holding-empty flag reads 0 in the clock after the write.
- R5: When the holding register holds a byte and the shift register is idle, the byte moves to the shift register on the next clock edge. After that edge the holding-empty flag reads 1 and the line shows the start bit.
- R6: A write in the same clock as that transfer is accepted. The new byte is sent as the next frame.
- R7: A write while the holding register is full and the shift register is busy is ignored. The frame in flight and the held byte are both sent unchanged, and no extra frame appears.
- R8: The transmitter-empty flag is 0 from the clock after an accepted write until the stop bit of the last queued frame has lasted its full sixteen ticks. It reads 1 in the clock after that final tick.
- R9: A byte held during a frame starts its own start bit right after the previous stop bit, with no gap of more than one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | Baud enable at sixteen times the bit rate, one clock wide |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte written by the host |
| txd | output | 1 | Serial output line, idle high |
| hold_empty | output | 1 | 1 = holding register can take a byte, 0 = full |
| tx_empty | output | 1 | 1 = both registers empty and the last stop bit finished |

## Verification
The bench works on the hand-off edges. One test writes a byte in the exact clock that the held byte enters the shifter. A design that only looked at the holding register would drop that byte and send one frame too few. Another test writes while both registers are full. A design that overwrote the held byte, or loaded the shifter mid-frame, would send a wrong or extra frame. The bench also checks the transmitter-empty flag in the final clocks of the stop bit and runs with a slow tick enable. A design that raised the flag early, or counted clocks instead of ticks, would release the line too soon or stretch every bit the wrong way.

// File: rtl/uart_tx_pkg.sv
// Package: uart_tx_pkg
// Holds the shared defaults and the state type of the transmit stage.
// Assumes nothing. It has no logic, only parameters and types.
package uart_tx_pkg;

    localparam int unsigned DEF_DATA_W = 8;   // bits per character
    localparam int unsigned DEF_OVS    = 16;  // enable ticks per bit

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_e;

endpackage

// File: rtl/uart_tx_hold.sv
// Module: uart_tx_hold
// Single-entry holding register between the host and the shifter.
// Assumes 'take' is high only in a clock where the shifter loads the held byte.
// A write is accepted when the register is empty, or when it empties in the same clock.
module uart_tx_hold #(
    parameter int unsigned DATA_W = uart_tx_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    logic accept;

    // Decide whether this clock's write is taken.
    always_comb begin
        accept = wr_en && (!full || take);
    end

    // Update the occupancy bit and the stored byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (accept) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    a_r4_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full) |=> full);

    a_r7_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !take) |=> ($stable(data) && full));

    a_r6_refill_on_take: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && take) |=> (full && data == $past(wr_data)));

endmodule

// File: rtl/uart_tx_shifter.sv
// Module: uart_tx_shifter
// Shift register and bit timer that send one frame: start, data LSB first, stop.
// Assumes 'load' is only high while 'idle' is high and 'tick' is one clock wide.
// Each bit lasts OVS ticks; the frame moves only on clocks with tick high.
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned OVS    = DEF_OVS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              txd,
    output logic              idle
);

    localparam int unsigned CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    tx_state_e         state;
    logic [CNT_W-1:0]  tick_cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              bit_done;

    // Flag the last tick of the current bit.
    always_comb begin
        bit_done = tick && (tick_cnt == CNT_LAST);
    end

    // Step through the frame states and shift the data out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= TX_IDLE;
            tick_cnt <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (load) begin
                        shreg    <= load_data;
                        state    <= TX_START;
                        tick_cnt <= '0;
                        bit_idx  <= '0;
                    end
                end
                default: begin
                    if (tick) begin
                        tick_cnt <= bit_done ? '0 : tick_cnt + 1'b1;
                    end
                    if (bit_done) begin
                        case (state)
                            TX_START: state <= TX_DATA;
                            TX_DATA: begin
                                shreg <= shreg >> 1;
                                if (bit_idx == IDX_LAST) begin
                                    state <= TX_STOP;
                                end else begin
                                    bit_idx <= bit_idx + 1'b1;
                                end
                            end
                            default: state <= TX_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end

    // Drive the line level from the frame state.
    always_comb begin
        case (state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            default:  txd = 1'b1;
        endcase
        idle = (state == TX_IDLE);
    end

    a_r3_no_tick_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TX_IDLE && !tick) |=> ($stable(state) && $stable(tick_cnt) && $stable(txd)));

    a_r2_start_is_low: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && load) |=> !txd);

    a_r2_stop_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_STOP && bit_done) |=> (idle && txd));

endmodule

// File: rtl/uart_tx_stage.sv
// Module: uart_tx_stage
// Double-buffered UART transmitter: holding register feeding a frame shifter.
// Assumes tick16 is an external 16x baud enable, one clock wide per tick.
// hold_empty rises when the shifter takes the byte; tx_empty rises when all is sent.
module uart_tx_stage
    import uart_tx_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned OVS    = DEF_OVS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_empty
);

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              sh_idle;
    logic              take;

    // Hand the held byte over whenever the shifter is idle.
    always_comb begin
        take       = sh_idle && hold_full;
        hold_empty = !hold_full;
        tx_empty   = sh_idle && !hold_full;
    end

    uart_tx_hold #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    uart_tx_shifter #(
        .DATA_W (DATA_W),
        .OVS    (OVS)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .load      (take),
        .load_data (hold_data),
        .txd       (txd),
        .idle      (sh_idle)
    );

    a_r5_transfer_next_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && sh_idle) |=> (!txd && !sh_idle));

    a_r8_empty_means_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> (txd && hold_empty));

    a_r4_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hold_empty) |=> !tx_empty);

endmodule

// File: tb/sim_uart_tx_stage.sv
// Bench: sim_uart_tx_stage
// Directed scenarios, one task each, for the double-buffered transmit stage.
module sim_uart_tx_stage;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd;
    logic       hold_empty;
    logic       tx_empty;

    int n_checks = 0;
    int n_fails  = 0;
    int tick_div = 1;
    int tick_cnt = 0;

    uart_tx_stage u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick16     (tick16),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .txd        (txd),
        .hold_empty (hold_empty),
        .tx_empty   (tx_empty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick enable: high one clock out of every tick_div clocks.
    always @(posedge clk) begin
        if (tick_cnt >= tick_div - 1) tick_cnt <= 0;
        else tick_cnt <= tick_cnt + 1;
    end
    assign tick16 = (tick_cnt == 0);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Wait for a start bit and sample every bit in its middle.
    task automatic recv_frame(input logic [7:0] exp, input bit check_end);
        logic [7:0] got;
        int found = 0;
        for (int i = 0; i < 20000; i++) begin
            if (txd == 1'b0) begin
                found = 1;
                break;
            end
            @(negedge clk);
        end
        chk(found == 1, "R2 start seen", found, 1);
        if (found == 0) return;
        repeat (8 * tick_div) @(negedge clk);
        chk(txd == 1'b0, "R2 start bit", int'(txd), 0);
        for (int k = 0; k < 8; k++) begin
            repeat (16 * tick_div) @(negedge clk);
            got[k] = txd;
        end
        chk(got == exp, "R2 R3 data bits", int'(got), int'(exp));
        repeat (16 * tick_div) @(negedge clk);
        chk(txd == 1'b1, "R2 stop bit", int'(txd), 1);
        if (check_end) begin
            chk(tx_empty == 1'b0, "R8 busy in stop", int'(tx_empty), 0);
            repeat (7) @(negedge clk);
            chk(tx_empty == 1'b0, "R8 busy at last stop tick", int'(tx_empty), 0);
            @(negedge clk);
            chk(tx_empty == 1'b1, "R8 empty after stop", int'(tx_empty), 1);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(txd == 1'b1, "R1 txd", int'(txd), 1);
        chk(hold_empty == 1'b1, "R1 hold_empty", int'(hold_empty), 1);
        chk(tx_empty == 1'b1, "R1 tx_empty", int'(tx_empty), 1);
    endtask

    task automatic t_single();
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = 8'hA5;
        @(negedge clk);
        wr_en   = 1'b0;
        chk(hold_empty == 1'b0, "R4 hold full after write", int'(hold_empty), 0);
        chk(tx_empty == 1'b0, "R8 busy after write", int'(tx_empty), 0);
        @(negedge clk);
        chk(hold_empty == 1'b1, "R5 hold empty after transfer", int'(hold_empty), 1);
        chk(txd == 1'b0, "R5 start after transfer", int'(txd), 0);
        recv_frame(8'hA5, 1'b1);
    endtask

    task automatic t_queue_and_ignore();
        write_byte(8'h3C);
        @(negedge clk);
        write_byte(8'hC3);
        chk(hold_empty == 1'b0, "R4 second byte held", int'(hold_empty), 0);
        write_byte(8'hFF);
        chk(hold_empty == 1'b0, "R7 still full", int'(hold_empty), 0);
        recv_frame(8'h3C, 1'b0);
        recv_frame(8'hC3, 1'b1);
        begin
            int lows = 0;
            for (int i = 0; i < 400; i++) begin
                @(negedge clk);
                if (txd == 1'b0) lows++;
            end
            chk(lows == 0, "R7 no extra frame", lows, 0);
        end
    endtask

    task automatic t_write_on_transfer();
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = 8'h81;
        @(negedge clk);
        wr_data = 8'h7E;
        @(negedge clk);
        wr_en   = 1'b0;
        chk(txd == 1'b0, "R6 first frame started", int'(txd), 0);
        chk(hold_empty == 1'b0, "R6 second byte taken", int'(hold_empty), 0);
        recv_frame(8'h81, 1'b0);
        begin
            int gap = 0;
            for (int i = 0; i < 40; i++) begin
                if (txd == 1'b0) break;
                gap++;
                @(negedge clk);
            end
            chk(gap <= 9, "R9 back-to-back gap", gap, 9);
        end
        recv_frame(8'h7E, 1'b1);
    endtask

    task automatic t_slow_tick();
        tick_div = 3;
        repeat (4) @(negedge clk);
        write_byte(8'h5A);
        recv_frame(8'h5A, 1'b0);
        repeat (20 * tick_div) @(negedge clk);
        chk(tx_empty == 1'b1, "R3 done with slow tick", int'(tx_empty), 1);
        tick_div = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        repeat (5) @(negedge clk);
        t_queue_and_ignore();
        t_write_on_transfer();
        t_slow_tick();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule